// File: doc/BRIEF.md
# Self-Clearing Latched Shift Register for a Character LCD

This block is a cycle-level model of a small serial link to a character display. It uses two lines: a serial data bit and one strobe that both shifts a stage register and copies it into an output latch. The latched word drives the display's four data lines, its register-select line and its enable line. One extra latched stage acts as the stage register's active-low master clear, so each frame wipes itself. Because shifting and latching share the strobe, the latch always shows the stages as they stood one strobe earlier.

A companion frame generator takes a nibble and a register-select value on a start pulse. It emits the serial pattern marker-first over eight data strobes, then two more strobes that let the clear stage flush the register. The marker bit reaches the enable output on the eighth strobe. The next strobe moves it into the clear stage, which zeroes the stage register. The strobe after that latches all zeros and releases the clear. A parameter picks what the guard stage next to the enable holds. It can hold zero, which keeps enable to a single cycle. It can hold a copy of register-select, which sets that line up one strobe early but stretches enable when register-select is 1.

Top module: `selfclr_lcd_tx`

## Requirements
- R1: While reset is low and after it is released, with no start, par_out, lcd_data, lcd_rs, lcd_en, busy, frame_done and ser_tick are all 0.
- R2: A start sampled at a clock edge while busy is 0 begins a frame; busy is 1 from that edge for exactly 10 cycles.
- R3: During a frame, ser_tick is 1 on each of the 10 busy cycles. ser_din in those cycles carries, in order: 1 (enable marker), guard bit, rs, nibble bits 3 down to 0, then 0, 0, 0. The guard bit is 0 in zero mode and rs in copy mode.
- R4: par_out takes the stage contents of the previous strobe. After the 8th strobe edge, lcd_en (par_out bit 6) is 1, lcd_rs (bit 4) equals rs and lcd_data (bits 3..0) equals the nibble. After the 7th edge, lcd_en is 0.
- R5: In zero mode, lcd_en is 1 for exactly one cycle per frame.
- R6: After the 9th strobe edge, par_out bit 7 (the clear stage) is 1. After the 10th edge, par_out is all zero.
- R7: While idle, ser_tick is 0 and par_out holds its value.
- R8: frame_done is a single-cycle pulse after the 10th strobe edge, with busy already 0.
- R9: A start asserted while busy has no effect: the frame in progress shows its own nibble and rs and gives one enable pulse.
- R10: In copy mode, lcd_rs equals rs after the 7th strobe edge. lcd_en is high for 1 cycle per frame when rs is 0 and for 2 cycles when rs is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request a frame (accepted when idle) |
| nibble | input | NIB_W | Data nibble for the display |
| rs | input | 1 | Register-select value for the frame |
| busy | output | 1 | Frame in progress |
| ser_tick | output | 1 | Shared shift/latch strobe |
| ser_din | output | 1 | Serial data line |
| par_out | output | NIB_W+4 | Whole latched output word |
| lcd_data | output | NIB_W | Latched data nibble |
| lcd_rs | output | 1 | Latched register-select |
| lcd_en | output | 1 | Latched enable |
| frame_done | output | 1 | Pulse after the self-clear completes |

## Verification
A wrong stage or latch state shows at the ports within one strobe, because every strobe copies the stage register to par_out. A misplaced pattern bit changes lcd_data or lcd_rs on the 8th strobe. A broken clear path leaves par_out nonzero after the 10th strobe. A bad guard bit shows as a second enable cycle on the 9th strobe. Counter or handshake faults move busy and frame_done away from their fixed 10-cycle window.

// File: rtl/lcd_sr_pkg.sv
package lcd_sr_pkg;
    // What the stage between register-select and enable carries
    typedef enum logic {
        GUARD_ZERO    = 1'b0,
        GUARD_COPY_RS = 1'b1
    } guard_mode_e;

    // marker + guard + register-select + trailing pad
    localparam int unsigned CTRL_STAGES = 4;
    // strobes needed for the self-clear after the data strobes
    localparam int unsigned CLEAR_TICKS = 2;
endpackage

// File: rtl/lcd_frame_gen.sv
module lcd_frame_gen
    import lcd_sr_pkg::*;
#(
    parameter int unsigned NIB_W = 4,
    parameter guard_mode_e GUARD = GUARD_ZERO
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NIB_W-1:0] nibble,
    input  logic             rs,
    output logic             tick,
    output logic             din,
    output logic             busy,
    output logic             done
);
    localparam int unsigned STAGES = NIB_W + CTRL_STAGES;
    localparam int unsigned TICKS  = STAGES + CLEAR_TICKS;
    localparam int unsigned CNT_W  = $clog2(TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [STAGES-1:0] pat;
        logic              done;
    } gen_t;

    gen_t gen_d, gen_q;
    logic guard_bit;

    generate
        if (GUARD == GUARD_COPY_RS) begin : g_guard_copy
            assign guard_bit = rs;
        end else begin : g_guard_zero
            assign guard_bit = 1'b0;
        end
    endgenerate

    always_comb begin
        gen_d      = gen_q;
        gen_d.done = 1'b0;
        if (gen_q.active) begin
            gen_d.pat = {gen_q.pat[STAGES-2:0], 1'b0};
            if (gen_q.cnt == LAST) begin
                gen_d.active = 1'b0;
                gen_d.cnt    = '0;
                gen_d.done   = 1'b1;
            end else begin
                gen_d.cnt = gen_q.cnt + 1'b1;
            end
        end else if (start) begin
            gen_d.active = 1'b1;
            gen_d.cnt    = '0;
            // sent MSB first: marker lands deepest, pad bit last
            gen_d.pat    = {1'b1, guard_bit, rs, nibble, 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign tick = gen_q.active;
    assign din  = gen_q.pat[STAGES-1];
    assign busy = gen_q.active;
    assign done = gen_q.done;

    // R3: serial line idles low
    a_r3_din_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !din);
    // R2: an idle start opens a frame
    a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R9: a start during a frame does not restart the count
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && gen_q.cnt != LAST) |=> (busy && gen_q.cnt != '0));
    // R8: frame_done only follows a busy cycle
    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
endmodule

// File: rtl/selfclr_shift_latch.sv
module selfclr_shift_latch #(
    parameter int unsigned STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              din,
    output logic [STAGES-1:0] par_q
);
    localparam int unsigned TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] sr;
        logic [STAGES-1:0] out;
    } sl_t;

    sl_t  sl_d, sl_q;
    logic clr_n;

    always_comb begin
        sl_d  = sl_q;
        clr_n = ~sl_q.out[TOP];
        if (tick) begin
            // one strobe both shifts and latches the old stages
            sl_d.out = sl_q.sr;
            sl_d.sr  = {sl_q.sr[TOP-1:0], din};
        end
        // top latched stage is the stage register's active-low clear
        if (!clr_n || sl_d.out[TOP]) sl_d.sr = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sl_q <= '0;
        else        sl_q <= sl_d;
    end

    assign par_q = sl_q.out;

    // R6: clear stage high empties the stage register
    a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        sl_q.out[TOP] |=> (sl_q.sr == '0));
    // R6: the strobe with clear active latches zeros
    a_r6_zero_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sl_q.out[TOP]) |=> (sl_q.out == '0));
    // R7: outputs hold between strobes
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sl_q.out));
endmodule

// File: rtl/selfclr_lcd_tx.sv
module selfclr_lcd_tx
    import lcd_sr_pkg::*;
#(
    parameter int unsigned NIB_W = 4,
    parameter guard_mode_e GUARD = GUARD_ZERO
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [NIB_W-1:0]             nibble,
    input  logic                         rs,
    output logic                         busy,
    output logic                         ser_tick,
    output logic                         ser_din,
    output logic [NIB_W+CTRL_STAGES-1:0] par_out,
    output logic [NIB_W-1:0]             lcd_data,
    output logic                         lcd_rs,
    output logic                         lcd_en,
    output logic                         frame_done
);
    localparam int unsigned STAGES = NIB_W + CTRL_STAGES;
    localparam int unsigned RS_POS = NIB_W;
    localparam int unsigned EN_POS = NIB_W + 2;

    lcd_frame_gen #(.NIB_W(NIB_W), .GUARD(GUARD)) u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .nibble (nibble),
        .rs     (rs),
        .tick   (ser_tick),
        .din    (ser_din),
        .busy   (busy),
        .done   (frame_done)
    );

    selfclr_shift_latch #(.STAGES(STAGES)) u_sl (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ser_tick),
        .din   (ser_din),
        .par_q (par_out)
    );

    assign lcd_data = par_out[NIB_W-1:0];
    assign lcd_rs   = par_out[RS_POS];
    assign lcd_en   = par_out[EN_POS];

    generate
        if (GUARD == GUARD_ZERO) begin : g_single_en
            // R5: enable never lasts two cycles
            a_r5_en_single: assert property (@(posedge clk) disable iff (!rst_n)
                lcd_en |=> !lcd_en);
        end
    endgenerate

    // R8: done is a lone pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
    // R6: a completed frame leaves the latch empty
    a_r6_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (par_out == '0));
endmodule

// File: tb/sim_selfclr_lcd_tx.sv
module sim_selfclr_lcd_tx;
    import lcd_sr_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [3:0] nibble = 4'h0;
    logic rs = 1'b0;

    logic busy0, tick0, din0, en0, rso0, done0;
    logic [7:0] par0;
    logic [3:0] data0;
    logic busy1, tick1, din1, en1, rso1, done1;
    logic [7:0] par1;
    logic [3:0] data1;

    int compared = 0;
    int mismatched = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    selfclr_lcd_tx #(.NIB_W(4), .GUARD(GUARD_ZERO)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .nibble(nibble), .rs(rs),
        .busy(busy0), .ser_tick(tick0), .ser_din(din0), .par_out(par0),
        .lcd_data(data0), .lcd_rs(rso0), .lcd_en(en0), .frame_done(done0));

    selfclr_lcd_tx #(.NIB_W(4), .GUARD(GUARD_COPY_RS)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start), .nibble(nibble), .rs(rs),
        .busy(busy1), .ser_tick(tick1), .ser_din(din1), .par_out(par1),
        .lcd_data(data1), .lcd_rs(rso1), .lcd_en(en1), .frame_done(done1));

    // {nibble, rs, expected copy-mode enable width}
    localparam logic [6:0] VEC [6] = '{
        {4'h3, 1'b0, 2'd1},
        {4'h2, 1'b0, 2'd1},
        {4'hA, 1'b1, 2'd2},
        {4'hF, 1'b1, 2'd2},
        {4'h0, 1'b0, 2'd1},
        {4'h5, 1'b1, 2'd2}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic [3:0] nib, input logic rsv, input int w1, input logic poke);
        int cnt0 = 0;
        int cnt1 = 0;
        logic [9:0] bits0 = {1'b1, 1'b0, rsv, nib, 3'b000};
        logic [9:0] bits1 = {1'b1, rsv,  rsv, nib, 3'b000};
        nibble = nib;
        rs     = rsv;
        start  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", busy0, 1);
        for (int k = 1; k <= 11; k++) begin
            if (k <= 10) begin
                chk("R3 strobe", tick0, 1);
                chk("R3 zero-mode bit", din0, bits0[10-k]);
                chk("R3 copy-mode bit", din1, bits1[10-k]);
                chk("R2 busy window", busy0, 1);
            end
            if (poke && k == 3) begin
                start  = 1'b1;
                nibble = ~nib;
                rs     = ~rsv;
            end
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            cnt0 += int'(en0);
            cnt1 += int'(en1);
            if (k == 7) begin
                chk("R4 enable low before 8th strobe", en0, 0);
                chk("R10 rs set up early", rso1, rsv);
            end
            if (k == 8) begin
                chk("R4 enable", en0, 1);
                chk(poke ? "R9 data kept" : "R4 data", data0, nib);
                chk(poke ? "R9 rs kept" : "R4 rs", rso0, rsv);
            end
            if (k == 9) chk("R6 clear stage", par0[7], 1);
            if (k == 10) begin
                chk("R6 latch empty", par0, 0);
                chk("R6 latch empty copy", par1, 0);
                chk("R8 done", done0, 1);
                chk("R8 busy low", busy0, 0);
            end
            if (k == 11) chk("R8 done single", done0, 0);
        end
        chk(poke ? "R9 single enable" : "R5 enable width", cnt0, 1);
        chk("R10 copy-mode enable width", cnt1, w1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 par in reset", par0, 0);
        chk("R1 busy in reset", busy0, 0);
        chk("R1 done in reset", done0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 par after reset", par0, 0);
        chk("R1 strobe after reset", tick0, 0);
        chk("R1 enable after reset", en0, 0);

        for (int i = 0; i < 6; i++)
            run_frame(VEC[i][6:3], VEC[i][2], int'(VEC[i][1:0]), 1'b0);

        // R7: idle cycles leave everything quiet
        for (int j = 0; j < 5; j++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R7 idle strobe", tick0, 0);
            chk("R7 idle hold", par0, 0);
        end

        // R9: start pulsed mid-frame with other values
        run_frame(4'h9, 1'b1, 2, 1'b1);
        // R9: nothing new begins after the ignored start
        @(posedge clk);
        @(negedge clk);
        chk("R9 no second frame", busy0, 0);

        // back-to-back frames
        run_frame(4'hC, 1'b0, 1, 1'b0);
        run_frame(4'h6, 1'b1, 2, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule